// File: doc/BRIEF.md
# TDM Transmit Time-Slot Serializer

This block drives one serial transmit line with a time-division frame made of byte-wide slots. A small per-slot classification table, supplied as a flat configuration vector, says what each slot carries. A slot can take a full byte from a general data FIFO. It can take a 7-bit sample from a voice FIFO, and the eighth bit position then gets a programmable filler. A slot can also be left unassigned and filled with a programmable pattern. The output is a data bit plus a drive-enable, so any bit can be left undriven on a shared line.

A frame is started by a frame-sync pulse. A programmable bit offset delays the first frame bit relative to that pulse. An optional framing bit precedes the first slot. The frame length in slots is programmable. When the last slot has been sent, the line stays undriven until the next frame starts. The whole block runs on the serial bit clock. Two elaboration parameters select whether frame-sync is captured on the falling clock edge and whether the output bits are launched on the falling clock edge. The FIFOs are first-word-fall-through: the head word is visible whenever the FIFO is not empty, and a pop strobe consumes it at the clock edge.

Top module: `tdm_tx_serializer`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `tx_oe` is 0, `tx_d` is 0, `underflow` is 0 and neither FIFO is popped.
- R2: When frame-sync is sampled high at rising edge k with offset d, the first frame bit is on the output after edge k+d. For d=0 that is edge k itself. A frame bit launched at edge j stays on the output until edge j+1.
- R3: A slot whose table code is 01 sends the data FIFO head byte MSB first with `tx_oe` high for all 8 bits. The data FIFO is popped exactly once, at the edge that launches the slot's first bit.
- R4: A slot whose table code is 10 takes a 7-bit word from the voice FIFO and pops it once, at the slot's first edge. The word is sent bit 6 first. The invalid position comes first when `cfg_inv_msb`=1 and last when it is 0.
- R5: The invalid bit of a voice slot follows `cfg_inv_fill`: 00 drives 0, 01 drives 1, and 1x leaves the line undriven.
- R6: A slot whose table code is 00 (unassigned) or 11 (reserved) sends 8 bits of the `cfg_fill` pattern and pops no FIFO. The `cfg_fill` codes are the same as for R5.
- R7: If the FIFO a slot needs is empty at the slot's first edge, the slot sends the `cfg_fill` pattern and pops nothing. `underflow` then rises one edge later and holds until reset.
- R8: With `cfg_fbit_en`=1, the first frame bit is a single framing bit of value `cfg_fbit_val` with `tx_oe` high, and slot 0 follows it.
- R9: A frame holds exactly `cfg_slots` slots, with a value of 0 treated as 1. After the last bit, `tx_oe` and `tx_d` are 0 until the next frame start.
- R10: A frame-sync sampled during a running frame or a pending offset restarts the offset count from that edge. The new frame then starts from its first bit and abandons the old one.
- R11: Whenever `tx_oe` is 0, `tx_d` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_i | input | 1 | Frame-sync pulse |
| cfg_slots | input | $clog2(MAX_SLOTS+1) | Slots per frame |
| cfg_map | input | 2*MAX_SLOTS | Per-slot class code, slot n at bits [2n+1:2n] |
| cfg_offset | input | OFF_W | Bit offset of the frame start after frame-sync |
| cfg_fbit_en | input | 1 | Insert a framing bit |
| cfg_fbit_val | input | 1 | Framing bit value |
| cfg_fill | input | 2 | Unassigned slot pattern code |
| cfg_inv_msb | input | 1 | Voice invalid bit is the MSB (1) or LSB (0) |
| cfg_inv_fill | input | 2 | Voice invalid bit code |
| dfifo_empty | input | 1 | Data FIFO empty |
| dfifo_data | input | SLOT_BITS | Data FIFO head word |
| dfifo_pop | output | 1 | Data FIFO pop strobe |
| vfifo_empty | input | 1 | Voice FIFO empty |
| vfifo_data | input | SLOT_BITS-1 | Voice FIFO head word |
| vfifo_pop | output | 1 | Voice FIFO pop strobe |
| tx_d | output | 1 | Serial data |
| tx_oe | output | 1 | Drive enable for the serial data |
| underflow | output | 1 | Sticky FIFO starvation flag |

## Verification
A wrong slot or bit counter shows at the ports within one bit time. The next bit goes out with the wrong value or drive state, or a pop strobe appears on a cycle other than a slot boundary. A lost or misapplied offset shifts the whole stream, and that is visible at the first bit after frame-sync. A bad frame limit shows as bits driven past the expected frame end, or a frame cut short. The bench keeps a queue of expected (drive, value) pairs built from the requirements and compares both output pins and both pop strobes on every cycle. Any divergence is therefore reported in the cycle where it first appears.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

   // per-slot classification carried in the configuration map
   typedef enum logic [1:0] {
      SK_UNUSED = 2'b00,
      SK_DATA   = 2'b01,
      SK_VOICE  = 2'b10,
      SK_RSVD   = 2'b11
   } slot_kind_e;

   // filler codes: 00 low, 01 high, 1x undriven
   function automatic logic fill_level(input logic [1:0] code);
      return (code == 2'b01);
   endfunction

   function automatic logic fill_drives(input logic [1:0] code);
      return !code[1];
   endfunction

endpackage

// File: rtl/tdm_slot_compose.sv
module tdm_slot_compose
   import tdm_tx_pkg::*;
#(
   parameter int SLOT_BITS = 8
) (
   input  logic [1:0]           kind_i,
   input  logic                 dfifo_empty_i,
   input  logic [SLOT_BITS-1:0] dfifo_data_i,
   input  logic                 vfifo_empty_i,
   input  logic [SLOT_BITS-2:0] vfifo_data_i,
   input  logic [1:0]           fill_i,
   input  logic                 inv_msb_i,
   input  logic [1:0]           inv_fill_i,
   output logic [SLOT_BITS-1:0] word_d_o,
   output logic [SLOT_BITS-1:0] word_oe_o,
   output logic                 take_data_o,
   output logic                 take_voice_o,
   output logic                 starve_o
);
   localparam int VB = SLOT_BITS - 1;

   logic [SLOT_BITS-1:0] pad_d, pad_oe;
   logic                 inv_d, inv_oe;

   assign pad_d  = {SLOT_BITS{fill_level(fill_i)}};
   assign pad_oe = {SLOT_BITS{fill_drives(fill_i)}};
   assign inv_d  = fill_level(inv_fill_i);
   assign inv_oe = fill_drives(inv_fill_i);

   always_comb begin
      word_d_o     = pad_d;
      word_oe_o    = pad_oe;
      take_data_o  = 1'b0;
      take_voice_o = 1'b0;
      starve_o     = 1'b0;
      unique case (slot_kind_e'(kind_i))
         SK_DATA: begin
            if (dfifo_empty_i) begin
               starve_o = 1'b1;
            end else begin
               word_d_o    = dfifo_data_i;
               word_oe_o   = '1;
               take_data_o = 1'b1;
            end
         end
         SK_VOICE: begin
            if (vfifo_empty_i) begin
               starve_o = 1'b1;
            end else begin
               take_voice_o = 1'b1;
               if (inv_msb_i) begin
                  word_d_o  = {inv_d, vfifo_data_i};
                  word_oe_o = {inv_oe, {VB{1'b1}}};
               end else begin
                  word_d_o  = {vfifo_data_i, inv_d};
                  word_oe_o = {{VB{1'b1}}, inv_oe};
               end
            end
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
   parameter int OFF_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fs_i,
   input  logic [OFF_W-1:0] offset_i,
   output logic             start_o
);
   logic             busy_q;
   logic [OFF_W-1:0] cnt_q;

   assign start_o = (fs_i && (offset_i == '0))
                 || (!fs_i && busy_q && (cnt_q == OFF_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (fs_i) begin
         busy_q <= (offset_i != '0);
         cnt_q  <= offset_i;
      end else if (busy_q) begin
         cnt_q <= cnt_q - OFF_W'(1);
         if (cnt_q == OFF_W'(1)) busy_q <= 1'b0;
      end
   end

   // R2: a pending delay always has a nonzero count left
   p_busy_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (cnt_q != '0));

   // R10: a frame-sync with nonzero offset leaves a pending delay
   p_resync_arms_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fs_i && offset_i != '0) |=> busy_q);

endmodule

// File: rtl/tdm_tx_shifter.sv
module tdm_tx_shifter #(
   parameter int MAX_SLOTS = 32,
   parameter int SLOT_BITS = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           start_i,
   input  logic [$clog2(MAX_SLOTS+1)-1:0] cfg_slots_i,
   input  logic [2*MAX_SLOTS-1:0]         cfg_map_i,
   input  logic                           fbit_en_i,
   input  logic                           fbit_val_i,
   input  logic [SLOT_BITS-1:0]           word_d_i,
   input  logic [SLOT_BITS-1:0]           word_oe_i,
   output logic                           slot_begin_o,
   output logic [1:0]                     slot_kind_o,
   output logic                           tx_d_o,
   output logic                           tx_oe_o
);
   localparam int CNT_W  = $clog2(MAX_SLOTS + 1);
   localparam int SLOT_W = $clog2(MAX_SLOTS);
   localparam int BIT_W  = $clog2(SLOT_BITS);
   localparam int SH_W   = SLOT_BITS - 1;

   logic              run_q;
   logic [SLOT_W-1:0] slot_q;
   logic [BIT_W-1:0]  bit_q;
   logic [SH_W-1:0]   sh_d_q, sh_oe_q;
   logic              tx_d_q, tx_oe_q;

   logic              eff_run, do_fbit, last_bit;
   logic [SLOT_W-1:0] eff_slot, last_slot;
   logic [BIT_W-1:0]  eff_bit;
   logic [CNT_W-1:0]  lim;

   assign lim       = (cfg_slots_i == '0) ? CNT_W'(1) : cfg_slots_i;
   assign last_slot = SLOT_W'(lim - CNT_W'(1));

   assign eff_run  = start_i | run_q;
   assign eff_slot = start_i ? '0 : slot_q;
   assign eff_bit  = start_i ? '0 : bit_q;
   assign do_fbit  = start_i & fbit_en_i;
   assign last_bit = (eff_bit == BIT_W'(SLOT_BITS - 1));

   assign slot_begin_o = eff_run && !do_fbit && (eff_bit == '0);
   assign slot_kind_o  = cfg_map_i[{eff_slot, 1'b0} +: 2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         slot_q  <= '0;
         bit_q   <= '0;
         sh_d_q  <= '0;
         sh_oe_q <= '0;
         tx_d_q  <= 1'b0;
         tx_oe_q <= 1'b0;
      end else if (do_fbit) begin
         tx_d_q  <= fbit_val_i;
         tx_oe_q <= 1'b1;
         run_q   <= 1'b1;
         slot_q  <= '0;
         bit_q   <= '0;
      end else if (eff_run) begin
         if (eff_bit == '0) begin
            tx_d_q  <= word_d_i[SLOT_BITS-1];
            tx_oe_q <= word_oe_i[SLOT_BITS-1];
            sh_d_q  <= word_d_i[SH_W-1:0];
            sh_oe_q <= word_oe_i[SH_W-1:0];
         end else begin
            tx_d_q  <= sh_d_q[SH_W-1];
            tx_oe_q <= sh_oe_q[SH_W-1];
            sh_d_q  <= {sh_d_q[SH_W-2:0], 1'b0};
            sh_oe_q <= {sh_oe_q[SH_W-2:0], 1'b0};
         end
         if (last_bit) begin
            bit_q <= '0;
            if (eff_slot == last_slot) begin
               run_q <= 1'b0;
            end else begin
               run_q  <= 1'b1;
               slot_q <= eff_slot + SLOT_W'(1);
            end
         end else begin
            run_q  <= 1'b1;
            bit_q  <= eff_bit + BIT_W'(1);
            slot_q <= eff_slot;
         end
      end else begin
         tx_d_q  <= 1'b0;
         tx_oe_q <= 1'b0;
      end
   end

   assign tx_d_o  = tx_d_q;
   assign tx_oe_o = tx_oe_q;

   // R9: the running slot index never passes the programmed frame end
   p_slot_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (slot_q <= last_slot));

   // R8: a framing bit goes out driven with the programmed value
   p_fbit_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
      do_fbit |=> (tx_oe_q && (tx_d_q == $past(fbit_val_i))));

endmodule

// File: rtl/tdm_tx_serializer.sv
module tdm_tx_serializer
   import tdm_tx_pkg::*;
#(
   parameter int MAX_SLOTS  = 32,
   parameter int SLOT_BITS  = 8,
   parameter int OFF_W      = 8,
   parameter bit FS_ON_FALL = 1'b0,
   parameter bit TX_ON_FALL = 1'b0
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           fs_i,
   input  logic [$clog2(MAX_SLOTS+1)-1:0] cfg_slots,
   input  logic [2*MAX_SLOTS-1:0]         cfg_map,
   input  logic [OFF_W-1:0]               cfg_offset,
   input  logic                           cfg_fbit_en,
   input  logic                           cfg_fbit_val,
   input  logic [1:0]                     cfg_fill,
   input  logic                           cfg_inv_msb,
   input  logic [1:0]                     cfg_inv_fill,
   input  logic                           dfifo_empty,
   input  logic [SLOT_BITS-1:0]           dfifo_data,
   output logic                           dfifo_pop,
   input  logic                           vfifo_empty,
   input  logic [SLOT_BITS-2:0]           vfifo_data,
   output logic                           vfifo_pop,
   output logic                           tx_d,
   output logic                           tx_oe,
   output logic                           underflow
);
   initial begin
      assert (MAX_SLOTS >= 2) else $error("MAX_SLOTS must be at least 2");
      assert (SLOT_BITS >= 3) else $error("SLOT_BITS must be at least 3");
      assert (OFF_W >= 1)     else $error("OFF_W must be at least 1");
   end

   logic                 fs_eff, start;
   logic                 slot_begin, take_d, take_v, starve;
   logic [1:0]           kind;
   logic [SLOT_BITS-1:0] word_d, word_oe;
   logic                 sh_d, sh_oe;
   logic                 uf_q;

   // frame-sync capture edge variant
   generate
      if (FS_ON_FALL) begin : g_fs_fall
         logic fs_q;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) fs_q <= 1'b0;
            else        fs_q <= fs_i;
         end
         assign fs_eff = fs_q;
      end else begin : g_fs_rise
         assign fs_eff = fs_i;
      end
   endgenerate

   tdm_frame_timer #(.OFF_W(OFF_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .fs_i     (fs_eff),
      .offset_i (cfg_offset),
      .start_o  (start)
   );

   tdm_tx_shifter #(.MAX_SLOTS(MAX_SLOTS), .SLOT_BITS(SLOT_BITS)) u_shift (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start),
      .cfg_slots_i  (cfg_slots),
      .cfg_map_i    (cfg_map),
      .fbit_en_i    (cfg_fbit_en),
      .fbit_val_i   (cfg_fbit_val),
      .word_d_i     (word_d),
      .word_oe_i    (word_oe),
      .slot_begin_o (slot_begin),
      .slot_kind_o  (kind),
      .tx_d_o       (sh_d),
      .tx_oe_o      (sh_oe)
   );

   tdm_slot_compose #(.SLOT_BITS(SLOT_BITS)) u_compose (
      .kind_i        (kind),
      .dfifo_empty_i (dfifo_empty),
      .dfifo_data_i  (dfifo_data),
      .vfifo_empty_i (vfifo_empty),
      .vfifo_data_i  (vfifo_data),
      .fill_i        (cfg_fill),
      .inv_msb_i     (cfg_inv_msb),
      .inv_fill_i    (cfg_inv_fill),
      .word_d_o      (word_d),
      .word_oe_o     (word_oe),
      .take_data_o   (take_d),
      .take_voice_o  (take_v),
      .starve_o      (starve)
   );

   assign dfifo_pop = slot_begin & take_d;
   assign vfifo_pop = slot_begin & take_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      uf_q <= 1'b0;
      else if (slot_begin && starve)   uf_q <= 1'b1;
   end
   assign underflow = uf_q;

   // data launch edge variant
   generate
      if (TX_ON_FALL) begin : g_tx_fall
         logic d_q, oe_q;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) begin
               d_q  <= 1'b0;
               oe_q <= 1'b0;
            end else begin
               d_q  <= sh_d;
               oe_q <= sh_oe;
            end
         end
         assign tx_d  = d_q;
         assign tx_oe = oe_q;
      end else begin : g_tx_rise
         assign tx_d  = sh_d;
         assign tx_oe = sh_oe;
      end
   endgenerate

   // R3: the data FIFO is never popped while empty
   p_dpop_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dfifo_pop |-> !dfifo_empty);

   // R4: the voice FIFO is never popped while empty
   p_vpop_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      vfifo_pop |-> !vfifo_empty);

   // R6: at most one FIFO is consumed per slot
   p_one_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dfifo_pop, vfifo_pop}));

   // R7: the starvation flag holds once set
   p_uf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |=> underflow);

   // R11: an undriven line carries a zero data bit
   p_hiz_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_oe |-> !tx_d);

endmodule

// File: tb/tb_tdm_tx_serializer.sv
module tb_tdm_tx_serializer;
   localparam int MS = 32;
   localparam int SB = 8;
   localparam int OW = 8;
   localparam int CW = $clog2(MS + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fs_i = 1'b0;
   logic [CW-1:0] cfg_slots = '0;
   logic [2*MS-1:0] cfg_map = '0;
   logic [OW-1:0] cfg_offset = '0;
   logic          cfg_fbit_en = 1'b0, cfg_fbit_val = 1'b0;
   logic [1:0]    cfg_fill = 2'b00, cfg_inv_fill = 2'b00;
   logic          cfg_inv_msb = 1'b0;
   logic          dfifo_empty = 1'b1, vfifo_empty = 1'b1;
   logic [SB-1:0] dfifo_data = '0;
   logic [SB-2:0] vfifo_data = '0;
   logic          dfifo_pop, vfifo_pop, tx_d, tx_oe, underflow;

   always #5 clk = ~clk;

   tdm_tx_serializer dut (
      .clk(clk), .rst_n(rst_n), .fs_i(fs_i), .cfg_slots(cfg_slots),
      .cfg_map(cfg_map), .cfg_offset(cfg_offset), .cfg_fbit_en(cfg_fbit_en),
      .cfg_fbit_val(cfg_fbit_val), .cfg_fill(cfg_fill), .cfg_inv_msb(cfg_inv_msb),
      .cfg_inv_fill(cfg_inv_fill), .dfifo_empty(dfifo_empty), .dfifo_data(dfifo_data),
      .dfifo_pop(dfifo_pop), .vfifo_empty(vfifo_empty), .vfifo_data(vfifo_data),
      .vfifo_pop(vfifo_pop), .tx_d(tx_d), .tx_oe(tx_oe), .underflow(underflow)
   );

   int    checks = 0, errors = 0;
   string cur_req = "R1";

   logic [SB-1:0] dq[$];
   logic [SB-2:0] vq[$];
   bit pend_d = 0, pend_v = 0;

   // reference model state
   logic [1:0] txq[$];
   int  m_dly = 0, m_nslot = 0;
   bit  m_pend = 0, m_active = 0, m_uf = 0;
   logic exp_d = 0, exp_oe = 0, exp_uf = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic upd_fifo();
      dfifo_empty = (dq.size() == 0);
      dfifo_data  = (dq.size() > 0) ? dq[0] : '0;
      vfifo_empty = (vq.size() == 0);
      vfifo_data  = (vq.size() > 0) ? vq[0] : '0;
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
      if (pend_d && dq.size() > 0) void'(dq.pop_front());
      if (pend_v && vq.size() > 0) void'(vq.pop_front());
      pend_d = 0;
      pend_v = 0;
      upd_fifo();
   endtask

   task automatic pulse_fs();
      fs_i = 1'b1;
      cyc();
      fs_i = 1'b0;
   endtask

   // {oe, d} for a filler code
   function automatic logic [1:0] fillpair(input logic [1:0] code);
      return code[1] ? 2'b00 : {1'b1, code[0]};
   endfunction

   always @(negedge clk) begin
      if (!rst_n) begin
         txq.delete();
         m_dly = 0; m_nslot = 0; m_pend = 0; m_active = 0; m_uf = 0;
         exp_d = 0; exp_oe = 0; exp_uf = 0;
         pend_d = 0; pend_v = 0;
      end else begin
         bit e_dp, e_vp;
         int lim;
         check(tx_oe === exp_oe, {cur_req, " tx_oe"}, tx_oe, exp_oe);
         check(tx_d === exp_d, {cur_req, " tx_d"}, tx_d, exp_d);
         check(underflow === exp_uf, "R7 underflow", underflow, exp_uf);
         e_dp = 0;
         e_vp = 0;
         lim = (cfg_slots == 0) ? 1 : int'(cfg_slots);
         if (fs_i) begin
            m_pend = 1;
            m_dly = int'(cfg_offset);
         end else if (m_dly > 0) begin
            m_dly--;
         end
         if (m_pend && m_dly == 0) begin
            m_pend = 0;
            txq.delete();
            m_nslot = 0;
            m_active = 1;
            if (cfg_fbit_en) txq.push_back({1'b1, cfg_fbit_val});
         end
         if (txq.size() == 0 && m_active) begin
            if (m_nslot < lim) begin
               logic [1:0] kind;
               kind = cfg_map[2*m_nslot +: 2];
               if (kind == 2'b01 && dq.size() > 0) begin
                  logic [SB-1:0] byt;
                  byt = dq[0];
                  for (int b = SB - 1; b >= 0; b--) txq.push_back({1'b1, byt[b]});
                  e_dp = 1;
               end else if (kind == 2'b10 && vq.size() > 0) begin
                  logic [SB-2:0] vw;
                  vw = vq[0];
                  if (cfg_inv_msb) txq.push_back(fillpair(cfg_inv_fill));
                  for (int b = SB - 2; b >= 0; b--) txq.push_back({1'b1, vw[b]});
                  if (!cfg_inv_msb) txq.push_back(fillpair(cfg_inv_fill));
                  e_vp = 1;
               end else begin
                  if (kind == 2'b01 || kind == 2'b10) m_uf = 1;
                  for (int b = 0; b < SB; b++) txq.push_back(fillpair(cfg_fill));
               end
               m_nslot++;
            end else begin
               m_active = 0;
            end
         end
         if (txq.size() > 0) begin
            logic [1:0] pr;
            pr = txq.pop_front();
            exp_oe = pr[1];
            exp_d = pr[0];
         end else begin
            exp_oe = 0;
            exp_d = 0;
         end
         exp_uf = m_uf;
         check(dfifo_pop === e_dp, {cur_req, " dfifo_pop"}, dfifo_pop, e_dp);
         check(vfifo_pop === e_vp, {cur_req, " vfifo_pop"}, vfifo_pop, e_vp);
         pend_d = dfifo_pop;
         pend_v = vfifo_pop;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int n;
      upd_fifo();
      repeat (3) cyc();
      // R1 reset state
      check(tx_oe == 0 && tx_d == 0, "R1 outputs in reset", {tx_oe, tx_d}, 0);
      check(underflow == 0, "R1 underflow in reset", underflow, 0);
      check(dfifo_pop == 0 && vfifo_pop == 0, "R1 pops in reset", {dfifo_pop, vfifo_pop}, 0);
      rst_n = 1'b1;
      cyc();
      check(tx_oe == 0 && tx_d == 0, "R1 outputs after reset", {tx_oe, tx_d}, 0);
      check(underflow == 0, "R1 underflow after reset", underflow, 0);

      // S1: mixed slot kinds, invalid bit as MSB driven high (R3 R4 R6)
      cur_req = "R3/R4/R6";
      cfg_slots = 4; cfg_map = '0;
      cfg_map[1:0] = 2'b01; cfg_map[3:2] = 2'b10; cfg_map[5:4] = 2'b00; cfg_map[7:6] = 2'b11;
      cfg_offset = 0; cfg_fbit_en = 0; cfg_fill = 2'b00;
      cfg_inv_msb = 1; cfg_inv_fill = 2'b01;
      dq.push_back(8'hA5); dq.push_back(8'h3C);
      vq.push_back(7'h55); vq.push_back(7'h12);
      upd_fifo();
      pulse_fs();
      repeat (45) cyc();
      check(dq.size() == 1, "R3 one data pop per frame", dq.size(), 1);
      check(vq.size() == 1, "R4 one voice pop per frame", vq.size(), 1);
      dq.delete(); vq.delete(); upd_fifo();

      // S2: framing bit, offset 3, invalid LSB undriven, fill ones (R2 R5 R8 R11)
      cur_req = "R2/R5/R8";
      cfg_slots = 3; cfg_map = '0;
      cfg_map[1:0] = 2'b10; cfg_map[3:2] = 2'b01; cfg_map[5:4] = 2'b00;
      cfg_offset = 3; cfg_fbit_en = 1; cfg_fbit_val = 1;
      cfg_inv_msb = 0; cfg_inv_fill = 2'b10; cfg_fill = 2'b01;
      dq.push_back(8'h81); vq.push_back(7'h6B); upd_fifo();
      pulse_fs();
      n = 0;
      while (!tx_oe && n < 10) begin cyc(); n++; end
      check(n == 3, "R2 offset delay in edges", n, 3);
      check(tx_d == 1, "R8 framing bit value", tx_d, 1);
      repeat (40) cyc();
      check(tx_oe == 0 && tx_d == 0, "R9 idle after frame", {tx_oe, tx_d}, 0);

      // S4: resync mid-frame with offset 2 (R10)
      cur_req = "R10";
      cfg_slots = 5; cfg_map = '0;
      for (int i = 0; i < 5; i++) cfg_map[2*i +: 2] = 2'b01;
      cfg_offset = 2; cfg_fbit_en = 0; cfg_fill = 2'b00;
      for (int i = 0; i < 8; i++) dq.push_back(8'(8'h10 + i * 8'h13));
      upd_fifo();
      pulse_fs();
      repeat (11) cyc();
      pulse_fs();
      repeat (55) cyc();
      check(dq.size() == 1, "R10 resync pops 2 then 5", dq.size(), 1);
      dq.delete(); upd_fifo();

      // S5: invalid MSB driven low (R5)
      cur_req = "R5";
      cfg_slots = 2; cfg_map = '0;
      cfg_map[1:0] = 2'b10; cfg_map[3:2] = 2'b10;
      cfg_offset = 1; cfg_inv_msb = 1; cfg_inv_fill = 2'b00; cfg_fill = 2'b00;
      vq.push_back(7'h7F); vq.push_back(7'h2A); upd_fifo();
      pulse_fs();
      repeat (25) cyc();
      check(vq.size() == 0, "R4 both voice words used", vq.size(), 0);

      // S3: starved FIFOs, undriven filler (R7 R11)
      cur_req = "R7/R11";
      cfg_slots = 2; cfg_map = '0;
      cfg_map[1:0] = 2'b01; cfg_map[3:2] = 2'b10;
      cfg_offset = 0; cfg_fill = 2'b10;
      pulse_fs();
      check(tx_oe == 0, "R7 starved slot undriven", tx_oe, 0);
      repeat (20) cyc();
      check(underflow == 1, "R7 underflow set", underflow, 1);

      // S6: full-length frame of unassigned and reserved slots (R6 R9)
      cur_req = "R6/R9";
      cfg_slots = 0; cfg_slots = CW'(MS); cfg_map = '0;
      for (int i = 1; i < MS; i += 2) cfg_map[2*i +: 2] = 2'b11;
      cfg_fill = 2'b01;
      dq.push_back(8'hEE); vq.push_back(7'h11); upd_fifo();
      pulse_fs();
      n = 0;
      for (int i = 0; i < 300; i++) begin
         if (tx_oe) n++;
         cyc();
      end
      check(n == MS * SB, "R9 driven bits per frame", n, MS * SB);
      check(dq.size() == 1 && vq.size() == 1, "R6 no pop for filler slots",
            dq.size() + vq.size(), 2);
      check(underflow == 1, "R7 underflow still held", underflow, 1);

      // frame length 0 behaves as one slot (R9)
      cur_req = "R9";
      cfg_slots = 0;
      pulse_fs();
      n = 0;
      for (int i = 0; i < 20; i++) begin
         if (tx_oe) n++;
         cyc();
      end
      check(n == SB, "R9 zero length means one slot", n, SB);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule